// File: doc/BRIEF.md
# Command Slot Status Tracker

This block keeps one active flag for each command slot of a single storage port and presents them, together with an attention summary, as a 32-bit read-only status word. A slot goes active when a controller issues it, either by pushing its number into the command execution queue (direct path) or by writing that slot's activation register (indirect path). It goes inactive again when the completion logic sends a retire pulse carrying the slot's index.

The most significant bit of the word is an attention flag. It summarises every enabled port interrupt condition except command completion, so software can tell apart "a command finished" from "something needs looking at". The same word can be read at a global alias address and at a per-port address. A read at either address can also clear the port's pending completion status. A control input suppresses that side effect. The clear is a one-cycle pulse issued in the cycle after the read, so the value returned is always the value held before the read's side effects.

Top module: `slot_status_tracker`

## Requirements
- R1: After reset every slot flag is 0, `rd_data` is 0 while no read is in progress, and `cmpl_stat_clr` is 0.
- R2: A cycle with `issue_vld` high sets the flag of slot `issue_idx`. Bit i of the status word is slot i.
- R3: A cycle with `act_wr_vld` high sets the flag of slot `act_wr_idx`.
- R4: A cycle with `cmpl_vld` high clears the flag of slot `cmpl_idx` and leaves the other flags unchanged.
- R5: When a set (from either path) and a retire hit the same slot in the same cycle, the flag ends up set.
- R6: An index of NUM_SLOTS or higher (31 with the defaults) on any of the three strobes changes no flag.
- R7: Bit 31 of the status word is the OR of `irq_status & irq_en` over all interrupt lines except line CMPL_IRQ_BIT (line 0 by default). The completion line never raises it.
- R8: With `rd_en` high, `rd_data` returns the status word when `rd_addr` equals GLB_ADDR (0x00) or PORT_ADDR (0x80). Any other address returns 0. `rd_data` is 0 whenever `rd_en` is low.
- R9: `rd_data` shows the flags as they stood before the clock edge that ends the read cycle. Slot events in that same cycle appear only on the next read.
- R10: A read that hits either address while `no_clr_on_rd` is 0 produces a single-cycle `cmpl_stat_clr` pulse in the following cycle. A read with `no_clr_on_rd` high, a read that misses both addresses, or no read at all produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_vld | input | 1 | Direct issue strobe from the command execution queue |
| issue_idx | input | IDX_W (5) | Slot index for the direct issue |
| act_wr_vld | input | 1 | Indirect issue strobe (activation register write) |
| act_wr_idx | input | IDX_W (5) | Slot index for the activation write |
| cmpl_vld | input | 1 | Retire strobe from the completion logic |
| cmpl_idx | input | IDX_W (5) | Slot index being retired |
| irq_status | input | NUM_IRQ (8) | Raw port interrupt conditions |
| irq_en | input | NUM_IRQ (8) | Per-condition enable mask |
| no_clr_on_rd | input | 1 | 1 suppresses the clear-on-read side effect |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W (8) | Register read address |
| rd_data | output | 32 | Read data, same cycle as `rd_en` |
| cmpl_stat_clr | output | 1 | Pulse clearing the port's completion status |

## Verification
The bench builds the tracker with its defaults: 31 slots, 5-bit indices, 8 interrupt lines with completion on line 0, and the two addresses at 0x00 and 0x80. With these values index 31 is a code the bench can drive that maps to no slot. The status word has no padding bits, so the attention flag sits directly above slot 30. This lets random traffic reach the out-of-range filter, the top slot and the attention bit in one word. Directed cases add set and retire collisions, reads at both aliases and at a miss address, and reads with the clear side effect both enabled and suppressed.

// File: rtl/sst_pkg.sv
package sst_pkg;
   // Width of the status word seen on the register bus.
   localparam int SST_WORD_W = 32;
   // Bit position of the attention summary within the word.
   localparam int SST_ATTN_BIT = SST_WORD_W - 1;

   typedef logic [SST_WORD_W-1:0] sst_word_t;
endpackage

// File: rtl/sst_slot_decode.sv
// Turns a strobe plus slot index into a one-hot slot vector; out-of-range
// indices decode to nothing.
module sst_slot_decode #(
   parameter int NUM_SLOTS = 31,
   parameter int IDX_W     = 5
) (
   input  logic                 vld,
   input  logic [IDX_W-1:0]     idx,
   output logic [NUM_SLOTS-1:0] hit
);
   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_bit
      assign hit[i] = vld && (idx == IDX_W'(i));
   end
endmodule

// File: rtl/sst_slot_bank.sv
// One active flag per slot. Set has priority over retire.
module sst_slot_bank #(
   parameter int NUM_SLOTS = 31
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SLOTS-1:0] set_vec,
   input  logic [NUM_SLOTS-1:0] clr_vec,
   output logic [NUM_SLOTS-1:0] active
);
   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)
            active[i] <= 1'b0;
         else if (set_vec[i])
            active[i] <= 1'b1;
         else if (clr_vec[i])
            active[i] <= 1'b0;
      end
   end

   AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> ((active & $past(set_vec)) == $past(set_vec))); // R5
   AST_RETIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_vec & ~set_vec) != '0) |=> ((active & $past(clr_vec & ~set_vec)) == '0)); // R4
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec == '0 && clr_vec == '0) |=> $stable(active)); // R6
endmodule

// File: rtl/sst_attn_reduce.sv
// Attention summary: enabled interrupt conditions OR-ed, completion excluded.
module sst_attn_reduce #(
   parameter int NUM_IRQ      = 8,
   parameter int CMPL_IRQ_BIT = 0
) (
   input  logic [NUM_IRQ-1:0] irq_status,
   input  logic [NUM_IRQ-1:0] irq_en,
   output logic               attn
);
   logic [NUM_IRQ-1:0] live;

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
      if (i == CMPL_IRQ_BIT) begin : g_skip
         assign live[i] = 1'b0;
      end else begin : g_keep
         assign live[i] = irq_status[i] & irq_en[i];
      end
   end

   assign attn = |live;

   always_comb begin
      if (irq_status == irq_status)
         AST_CMPL_SILENT: assert (!(((irq_status & irq_en) == (NUM_IRQ'(1) << CMPL_IRQ_BIT)) && attn)); // R7
   end
endmodule

// File: rtl/sst_read_port.sv
// Address decode, word assembly and the deferred clear-on-read pulse.
module sst_read_port
   import sst_pkg::*;
#(
   parameter int                NUM_SLOTS = 31,
   parameter int                ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] GLB_ADDR  = 8'h00,
   parameter logic [ADDR_W-1:0] PORT_ADDR = 8'h80
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rd_en,
   input  logic [ADDR_W-1:0]    rd_addr,
   input  logic                 no_clr_on_rd,
   input  logic [NUM_SLOTS-1:0] active,
   input  logic                 attn,
   output sst_word_t            rd_data,
   output logic                 cmpl_stat_clr
);
   localparam int PAD_W = SST_WORD_W - 1 - NUM_SLOTS;

   sst_word_t word;
   logic      addr_hit;

   if (PAD_W == 0) begin : g_full
      assign word = {attn, active};
   end else begin : g_padded
      assign word = {attn, {PAD_W{1'b0}}, active};
   end

   assign addr_hit = rd_en && ((rd_addr == GLB_ADDR) || (rd_addr == PORT_ADDR));
   assign rd_data  = addr_hit ? word : '0;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cmpl_stat_clr <= 1'b0;
      else
         cmpl_stat_clr <= addr_hit && !no_clr_on_rd;
   end

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> (rd_data == '0)); // R8
   AST_NO_READ_NO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !cmpl_stat_clr); // R10
   AST_SUPPRESSED_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      no_clr_on_rd |=> !cmpl_stat_clr); // R10
endmodule

// File: rtl/slot_status_tracker.sv
module slot_status_tracker
   import sst_pkg::*;
#(
   parameter int                NUM_SLOTS    = 31,
   parameter int                IDX_W        = 5,
   parameter int                NUM_IRQ      = 8,
   parameter int                CMPL_IRQ_BIT = 0,
   parameter int                ADDR_W       = 8,
   parameter logic [ADDR_W-1:0] GLB_ADDR     = 8'h00,
   parameter logic [ADDR_W-1:0] PORT_ADDR    = 8'h80
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               issue_vld,
   input  logic [IDX_W-1:0]   issue_idx,
   input  logic               act_wr_vld,
   input  logic [IDX_W-1:0]   act_wr_idx,
   input  logic               cmpl_vld,
   input  logic [IDX_W-1:0]   cmpl_idx,
   input  logic [NUM_IRQ-1:0] irq_status,
   input  logic [NUM_IRQ-1:0] irq_en,
   input  logic               no_clr_on_rd,
   input  logic               rd_en,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [31:0]        rd_data,
   output logic               cmpl_stat_clr
);
   localparam int MAX_SLOTS = SST_WORD_W - 1;

   if (NUM_SLOTS < 1 || NUM_SLOTS > MAX_SLOTS) begin : g_bad_slots
      $error("NUM_SLOTS must lie in 1..%0d", MAX_SLOTS);
   end
   if ((2 ** IDX_W) < NUM_SLOTS) begin : g_bad_idx
      $error("IDX_W too narrow for NUM_SLOTS");
   end
   if (CMPL_IRQ_BIT < 0 || CMPL_IRQ_BIT >= NUM_IRQ) begin : g_bad_irq
      $error("CMPL_IRQ_BIT outside interrupt vector");
   end
   if (GLB_ADDR == PORT_ADDR) begin : g_bad_addr
      $error("alias addresses must differ");
   end

   logic [NUM_SLOTS-1:0] set_direct;
   logic [NUM_SLOTS-1:0] set_indirect;
   logic [NUM_SLOTS-1:0] retire;
   logic [NUM_SLOTS-1:0] active;
   logic                 attn;

   sst_slot_decode #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_dec_issue (
      .vld(issue_vld), .idx(issue_idx), .hit(set_direct));
   sst_slot_decode #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_dec_act (
      .vld(act_wr_vld), .idx(act_wr_idx), .hit(set_indirect));
   sst_slot_decode #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_dec_cmpl (
      .vld(cmpl_vld), .idx(cmpl_idx), .hit(retire));

   sst_slot_bank #(.NUM_SLOTS(NUM_SLOTS)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .set_vec(set_direct | set_indirect),
      .clr_vec(retire),
      .active(active));

   sst_attn_reduce #(.NUM_IRQ(NUM_IRQ), .CMPL_IRQ_BIT(CMPL_IRQ_BIT)) u_attn (
      .irq_status(irq_status), .irq_en(irq_en), .attn(attn));

   sst_read_port #(
      .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W),
      .GLB_ADDR(GLB_ADDR), .PORT_ADDR(PORT_ADDR)
   ) u_rd (
      .clk(clk), .rst_n(rst_n),
      .rd_en(rd_en), .rd_addr(rd_addr), .no_clr_on_rd(no_clr_on_rd),
      .active(active), .attn(attn),
      .rd_data(rd_data), .cmpl_stat_clr(cmpl_stat_clr));

   AST_DIRECT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_vld && (int'(issue_idx) < NUM_SLOTS)) |=> (active[$past(issue_idx)] == 1'b1)); // R2
   AST_INDIRECT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (act_wr_vld && (int'(act_wr_idx) < NUM_SLOTS)) |=> (active[$past(act_wr_idx)] == 1'b1)); // R3
endmodule

// File: tb/slot_status_tracker_tb.sv
module slot_status_tracker_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_vld = 0, act_wr_vld = 0, cmpl_vld = 0;
   logic [4:0]  issue_idx = 0, act_wr_idx = 0, cmpl_idx = 0;
   logic [7:0]  irq_status = 0, irq_en = 0;
   logic        no_clr_on_rd = 0, rd_en = 0;
   logic [7:0]  rd_addr = 0;
   logic [31:0] rd_data;
   logic        cmpl_stat_clr;

   int tests = 0, fails = 0;
   bit done = 0;
   logic [30:0] m_act = '0;
   logic        m_clr = 1'b0;

   always #2 clk = ~clk;

   slot_status_tracker u_dut (
      .clk(clk), .rst_n(rst_n),
      .issue_vld(issue_vld), .issue_idx(issue_idx),
      .act_wr_vld(act_wr_vld), .act_wr_idx(act_wr_idx),
      .cmpl_vld(cmpl_vld), .cmpl_idx(cmpl_idx),
      .irq_status(irq_status), .irq_en(irq_en),
      .no_clr_on_rd(no_clr_on_rd), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .cmpl_stat_clr(cmpl_stat_clr));

   function automatic logic [31:0] exp_word(logic [30:0] act, logic [7:0] st, logic [7:0] en);
      logic a;
      a = |(st & en & 8'hFE);
      return {a, act};
   endfunction

   function automatic logic [30:0] slot_mask(logic v, logic [4:0] i);
      logic [30:0] m;
      m = '0;
      if (v && i < 5'd31) m[i] = 1'b1;
      return m;
   endfunction

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic idle();
      issue_vld = 0; act_wr_vld = 0; cmpl_vld = 0; rd_en = 0;
      rd_addr = 8'h00; no_clr_on_rd = 0;
   endtask

   // Inputs are already driven (just after a falling edge).
   task automatic step(string tag);
      logic hit;
      logic [30:0] s, c;
      #1;
      hit = rd_en && (rd_addr == 8'h00 || rd_addr == 8'h80);
      chk(tag, "rd_data", rd_data, hit ? exp_word(m_act, irq_status, irq_en) : 32'h0);
      chk(tag, "cmpl_stat_clr", {31'b0, cmpl_stat_clr}, {31'b0, m_clr});
      m_clr = hit && !no_clr_on_rd;
      s = slot_mask(issue_vld, issue_idx) | slot_mask(act_wr_vld, act_wr_idx);
      c = slot_mask(cmpl_vld, cmpl_idx);
      m_act = (m_act & ~c) | s;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic read_at(string tag, logic [7:0] a, logic noclr);
      idle(); rd_en = 1; rd_addr = a; no_clr_on_rd = noclr;
      step(tag);
      idle();
   endtask

   initial begin
      void'($urandom(32'd20240611));
      idle();
      repeat (3) @(negedge clk);
      // R1: reset state seen at the ports while reset is still held
      #1;
      chk("R1", "cmpl_stat_clr in reset", {31'b0, cmpl_stat_clr}, 32'h0);
      @(negedge clk);
      rst_n = 1;
      read_at("R1", 8'h00, 1'b1);
      step("R1");

      // R2 direct issue
      issue_vld = 1; issue_idx = 5; step("R2"); idle();
      read_at("R2", 8'h00, 1'b1);
      // R3 indirect issue of top slot
      act_wr_vld = 1; act_wr_idx = 30; step("R3"); idle();
      read_at("R3", 8'h80, 1'b1);
      // R4 retire slot 5, slot 30 kept
      cmpl_vld = 1; cmpl_idx = 5; step("R4"); idle();
      read_at("R4", 8'h00, 1'b1);
      // R5 collisions on both set paths
      issue_vld = 1; issue_idx = 7; cmpl_vld = 1; cmpl_idx = 7; step("R5"); idle();
      act_wr_vld = 1; act_wr_idx = 30; cmpl_vld = 1; cmpl_idx = 30; step("R5"); idle();
      read_at("R5", 8'h00, 1'b1);
      // R6 out-of-range index on all strobes
      issue_vld = 1; issue_idx = 31; act_wr_vld = 1; act_wr_idx = 31;
      cmpl_vld = 1; cmpl_idx = 31; step("R6"); idle();
      read_at("R6", 8'h00, 1'b1);
      // R7 attention
      irq_status = 8'h01; irq_en = 8'hFF; read_at("R7", 8'h00, 1'b1);
      irq_status = 8'h04; irq_en = 8'h00; read_at("R7", 8'h00, 1'b1);
      irq_status = 8'h84; irq_en = 8'h80; read_at("R7", 8'h80, 1'b1);
      irq_status = 8'h00; irq_en = 8'h00;
      // R8 miss address and R10 no pulse after it
      read_at("R8", 8'h40, 1'b0);
      step("R10");
      // R10 clear pulse after a hit, single cycle
      read_at("R10", 8'h80, 1'b0);
      step("R10");
      step("R10");
      read_at("R10", 8'h00, 1'b1);
      step("R10");
      // R9 same-cycle event not visible in the read
      issue_vld = 1; issue_idx = 9; rd_en = 1; rd_addr = 8'h00; no_clr_on_rd = 1;
      step("R9"); idle();
      cmpl_vld = 1; cmpl_idx = 30; rd_en = 1; no_clr_on_rd = 1; step("R9"); idle();
      read_at("R9", 8'h00, 1'b1);

      // random traffic
      for (int n = 0; n < 600; n++) begin
         logic [1:0] sel;
         issue_vld  = $urandom_range(0, 1) == 1;
         issue_idx  = 5'($urandom);
         act_wr_vld = $urandom_range(0, 3) == 0;
         act_wr_idx = 5'($urandom);
         cmpl_vld   = $urandom_range(0, 1) == 1;
         cmpl_idx   = $urandom_range(0, 3) == 0 ? issue_idx : 5'($urandom);
         irq_status = 8'($urandom);
         irq_en     = 8'($urandom);
         no_clr_on_rd = $urandom_range(0, 1) == 1;
         rd_en      = $urandom_range(0, 1) == 1;
         sel        = 2'($urandom);
         rd_addr    = sel == 2'd0 ? 8'h00 : sel == 2'd1 ? 8'h80 :
                      sel == 2'd2 ? 8'h40 : 8'($urandom);
         step("R2 R3 R4 R5 R6 R7 R8 R9 R10");
      end
      idle();
      step("R10");

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule